// File: doc/BRIEF.md
# Asynchronous DRAM Access Classifier

This block sits on the device side of a page-mode DRAM bus. It watches the four active-low strobes (row strobe, column strobe, write enable, output enable) and works out what kind of access the controller performed. It latches the multiplexed row and column address, writes or reads a small internal array, and decides when the 4-bit data bus is driven and when it is left in high impedance. A test environment uses it as a stand-in memory to check a DRAM controller against.

The strobes come from another clock domain. They are oversampled by the block clock through a two-flop synchroniser, and every decision is made on edges of the synchronised copies. The address and write data pass through an identical synchroniser so that they stay aligned with the strobes. Analog timing limits are not checked. The block only looks at the order in which edges arrive. When an access finishes, it reports the access type and the row involved in a single-clock pulse.

The array is `2**(MEM_ROW_W+MEM_COL_W)` words of `DATA_W` bits. It is indexed by the low bits of the latched row and column, so a small array can stand in for the full-size one.

Top module: `dram_cycle_decoder`

## Requirements
- R1: With the row open and write enable high at the column strobe's falling edge, the word at (row, column) is loaded into the output holder. The data bus is driven with it while both column strobe and output enable are low. Taking output enable high releases the bus, and taking it low again re-drives the same word. A read is reported when the column strobe rises.
- R2: Write enable low before the column strobe falls is an early write. The input word is stored and `earlyWrite` is high until the column strobe rises. The bus stays in high impedance for the whole access even with output enable low. An early write is reported when the column strobe rises.
- R3: Write enable falling during a read while output enable is high is a late write. The input word is stored and the bus stays released. If output enable then goes low while the column strobe is still low, the word read before the write is driven. A late write is reported.
- R4: Write enable falling during a read while the bus is already driven is a read-modify-write. The input word is stored and the bus keeps driving the old word until the column strobe rises. A read-modify-write is reported. With output enable held low, a late write can therefore never occur.
- R5: Whenever the synchronised column strobe is high, the data bus is released. A column strobe rise clears the output holder.
- R6: While the row strobe stays low, each column-strobe pulse is a separate access on the same row, and each one is reported with that row.
- R7: A row strobe pulse with the column strobe high throughout is a row-only refresh. It is reported with the latched row when the row strobe rises.
- R8: The row strobe falling while the column strobe is already low, with no column access pending, is a counter refresh. It is reported with the internal counter value when the row strobe rises. The counter is `ADDR_W` bits wide, starts at zero after reset and advances by one on every counter-driven refresh.
- R9: The row strobe pulsing while the column strobe is held low after a column access is a hidden refresh. It also uses and advances the counter, and the bus keeps its held data throughout. The hidden refresh is reported at the row strobe rise. The pending column access is reported later, at the column strobe rise.
- R10: `cycleValid` is high for one clock per finished access, and `cycleKind` is 0 when it is low. The codes are: read 1, early write 2, late write 3, read-modify-write 4, row-only refresh 5, counter refresh 6, hidden refresh 7. After reset `cycleValid`, `earlyWrite` and `dqOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the strobes |
| rstN | input | 1 | Active-low asynchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DATA_W | Write data from the bus |
| dqOut | output | DATA_W | Read data toward the bus |
| dqOe | output | 1 | High when the block drives the bus |
| earlyWrite | output | 1 | Early-write detection flag |
| cycleValid | output | 1 | One-clock pulse when an access finishes |
| cycleKind | output | 3 | Access type code, valid with cycleValid |
| cycleRow | output | ADDR_W | Row of the finished access (counter value for refresh) |

## Verification
The hardest states to reach from the ports are the hidden refresh and the re-drive of old read data after a late write. Both need the column strobe held low across other strobe activity. The bench reaches them with scripted sequences: it starts a read, keeps the column strobe low, then pulses the row strobe or lowers and raises output enable and write enable. It checks the bus value and the order of the reported accesses after each step. A behavioural model keeps its own copy of the memory, the refresh counter and a queue of expected reports. The model is compared on every clock against the report pulses.

// File: rtl/dram_cycle_pkg.sv
package dram_cycle_pkg;

  typedef enum logic [2:0] {
    CK_NONE       = 3'd0,
    CK_READ       = 3'd1,
    CK_EARLY_WR   = 3'd2,
    CK_LATE_WR    = 3'd3,
    CK_RMW        = 3'd4,
    CK_ROW_REF    = 3'd5,
    CK_CBR_REF    = 3'd6,
    CK_HIDDEN_REF = 3'd7
  } cycKind_e;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_OPEN = 2'd1,
    RS_REF  = 2'd2
  } rowState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic rowLatch;   // capture row address
    logic colAccess;  // column strobe fell inside an open row
    logic wrCol;      // that column access is an early write
    logic wrLate;     // write after the column access started
    logic holdClear;  // column strobe rose: drop held read data
    logic refStep;    // advance refresh counter
    logic driveOk;    // column strobe and output enable both low
  } dpStrobe_t;

endpackage

// File: rtl/dram_sync.sv
module dram_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_cycle_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] rowQ,
  input  logic [ADDR_W-1:0] refQ,
  input  logic              dqOe,
  output dpStrobe_t         stb,
  output logic              earlyWrite,
  output logic              cycleValid,
  output cycKind_e          cycleKind,
  output logic [ADDR_W-1:0] cycleRow
);

  logic [3:0] syncOut;
  logic [3:0] prevS;

  dram_sync #(.W(4), .RST_VAL(4'hF)) uStrobeSync (
    .clk (clk),
    .rstN(rstN),
    .din ({rasN, casN, weN, oeN}),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevS <= 4'hF;
    else       prevS <= syncOut;
  end

  logic rasS, casS, weS, oeS;
  assign rasS = syncOut[3];
  assign casS = syncOut[2];
  assign weS  = syncOut[1];
  assign oeS  = syncOut[0];

  logic rasFall, rasRise, casFall, casRise, weFall;
  assign rasFall = prevS[3] & ~rasS;
  assign rasRise = ~prevS[3] & rasS;
  assign casFall = prevS[2] & ~casS;
  assign casRise = ~prevS[2] & casS;
  assign weFall  = prevS[1] & ~weS;

  rowState_e         rowState;
  logic              rowHadCol;
  logic              colPending;
  cycKind_e          colKind;
  cycKind_e          refKind;
  logic [ADDR_W-1:0] refRow;
  logic              deferValid;
  cycKind_e          deferKind;
  logic [ADDR_W-1:0] deferRow;

  logic colStart, lateHit, colEnd, rasEnd;
  cycKind_e          rasKind;
  logic [ADDR_W-1:0] rasRow;

  always_comb begin
    colStart = (rowState == RS_OPEN) && casFall && !rasS;
    lateHit  = colPending && (colKind == CK_READ) && weFall && !casS;
    colEnd   = casRise && colPending;
    rasEnd   = rasRise && (((rowState == RS_OPEN) && !rowHadCol && !colStart)
                           || (rowState == RS_REF));
    rasKind  = (rowState == RS_REF) ? refKind : CK_ROW_REF;
    rasRow   = (rowState == RS_REF) ? refRow : rowQ;

    stb           = '0;
    stb.driveOk   = ~casS & ~oeS;
    stb.rowLatch  = rasFall & casS;
    stb.refStep   = rasFall & ~casS;
    stb.colAccess = colStart;
    stb.wrCol     = colStart & ~weS;
    stb.wrLate    = lateHit;
    stb.holdClear = casRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowState   <= RS_IDLE;
      rowHadCol  <= 1'b0;
      colPending <= 1'b0;
      colKind    <= CK_NONE;
      refKind    <= CK_NONE;
      refRow     <= '0;
      earlyWrite <= 1'b0;
      deferValid <= 1'b0;
      deferKind  <= CK_NONE;
      deferRow   <= '0;
      cycleValid <= 1'b0;
      cycleKind  <= CK_NONE;
      cycleRow   <= '0;
    end else begin
      cycleValid <= 1'b0;
      cycleKind  <= CK_NONE;
      deferValid <= 1'b0;

      // report: column end wins, a coincident row end waits one clock
      if (colEnd) begin
        cycleValid <= 1'b1;
        cycleKind  <= colKind;
        cycleRow   <= rowQ;
        if (rasEnd) begin
          deferValid <= 1'b1;
          deferKind  <= rasKind;
          deferRow   <= rasRow;
        end
      end else if (rasEnd) begin
        cycleValid <= 1'b1;
        cycleKind  <= rasKind;
        cycleRow   <= rasRow;
      end else if (deferValid) begin
        cycleValid <= 1'b1;
        cycleKind  <= deferKind;
        cycleRow   <= deferRow;
      end

      // row strobe tracking
      if (rasRise) begin
        rowState <= RS_IDLE;
      end else if (rasFall) begin
        if (casS) begin
          rowState  <= RS_OPEN;
          rowHadCol <= 1'b0;
        end else begin
          rowState <= RS_REF;
          refKind  <= colPending ? CK_HIDDEN_REF : CK_CBR_REF;
          refRow   <= refQ;
        end
      end

      // column access tracking
      if (colStart) begin
        colPending <= 1'b1;
        rowHadCol  <= 1'b1;
        colKind    <= weS ? CK_READ : CK_EARLY_WR;
        earlyWrite <= ~weS;
      end else if (lateHit) begin
        colKind <= dqOe ? CK_RMW : CK_LATE_WR;
      end else if (casRise) begin
        colPending <= 1'b0;
        earlyWrite <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dram_cycle_datapath.sv
module dram_cycle_datapath
  import dram_cycle_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 4,
  parameter int MEM_ROW_W = 3,
  parameter int MEM_COL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  input  dpStrobe_t         stb,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [ADDR_W-1:0] rowQ,
  output logic [ADDR_W-1:0] refQ
);

  localparam int IDX_W     = MEM_ROW_W + MEM_COL_W;
  localparam int MEM_DEPTH = 1 << IDX_W;
  localparam int BUS_W     = ADDR_W + DATA_W;

  logic [BUS_W-1:0]     busS;
  logic [ADDR_W-1:0]    addrS;
  logic [DATA_W-1:0]    dinS;

  dram_sync #(.W(BUS_W), .RST_VAL('0)) uBusSync (
    .clk (clk),
    .rstN(rstN),
    .din ({addr, dqIn}),
    .dout(busS)
  );

  assign addrS = busS[BUS_W-1:DATA_W];
  assign dinS  = busS[DATA_W-1:0];

  logic [DATA_W-1:0]    memArr [MEM_DEPTH];
  logic [MEM_COL_W-1:0] colReg;
  logic [DATA_W-1:0]    holdData;
  logic                 holdValid;

  function automatic logic [IDX_W-1:0] memIdx(input logic [MEM_ROW_W-1:0] r,
                                              input logic [MEM_COL_W-1:0] c);
    return {r, c};
  endfunction

  logic [IDX_W-1:0] colIdx, lateIdx;
  assign colIdx  = memIdx(rowQ[MEM_ROW_W-1:0], addrS[MEM_COL_W-1:0]);
  assign lateIdx = memIdx(rowQ[MEM_ROW_W-1:0], colReg);

  always_ff @(posedge clk) begin
    if (stb.colAccess && stb.wrCol) memArr[colIdx]  <= dinS;
    else if (stb.wrLate)            memArr[lateIdx] <= dinS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ      <= '0;
      refQ      <= '0;
      colReg    <= '0;
      holdData  <= '0;
      holdValid <= 1'b0;
    end else begin
      if (stb.rowLatch) rowQ <= addrS;
      if (stb.refStep)  refQ <= refQ + 1'b1;
      if (stb.colAccess) begin
        colReg <= addrS[MEM_COL_W-1:0];
        if (stb.wrCol) begin
          holdValid <= 1'b0;
        end else begin
          holdData  <= memArr[colIdx];
          holdValid <= 1'b1;
        end
      end else if (stb.holdClear) begin
        holdValid <= 1'b0;
      end
    end
  end

  assign dqOut = holdData;
  assign dqOe  = holdValid & stb.driveOk;

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_cycle_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 4,
  parameter int MEM_ROW_W = 3,
  parameter int MEM_COL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              earlyWrite,
  output logic              cycleValid,
  output logic [2:0]        cycleKind,
  output logic [ADDR_W-1:0] cycleRow
);

  dpStrobe_t         stb;
  logic [ADDR_W-1:0] rowQ;
  logic [ADDR_W-1:0] refQ;
  cycKind_e          kindE;

  dram_cycle_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .oeN       (oeN),
    .rowQ      (rowQ),
    .refQ      (refQ),
    .dqOe      (dqOe),
    .stb       (stb),
    .earlyWrite(earlyWrite),
    .cycleValid(cycleValid),
    .cycleKind (kindE),
    .cycleRow  (cycleRow)
  );

  dram_cycle_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MEM_ROW_W(MEM_ROW_W),
    .MEM_COL_W(MEM_COL_W)
  ) uDp (
    .clk  (clk),
    .rstN (rstN),
    .addr (addr),
    .dqIn (dqIn),
    .stb  (stb),
    .dqOut(dqOut),
    .dqOe (dqOe),
    .rowQ (rowQ),
    .refQ (refQ)
  );

  assign cycleKind = kindE;

endmodule

// File: rtl/dram_cycle_checker.sv
module dram_cycle_checker (
  input logic       clk,
  input logic       rstN,
  input logic       casN,
  input logic       weN,
  input logic       oeN,
  input logic       dqOe,
  input logic       earlyWrite,
  input logic       cycleValid,
  input logic [2:0] cycleKind
);

  // R1: the bus is only driven when output enable was low at the synchroniser tap
  a_r1_drive_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !$past(oeN, 2));

  // R2: an early write never drives the bus
  a_r2_early_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    earlyWrite |-> !dqOe);

  // R2: the early flag only rises when write enable preceded the column strobe
  a_r2_early_needs_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(earlyWrite) |-> !$past(weN, 3));

  // R5: column strobe high means bus released
  a_r5_cas_high_hiz: assert property (@(posedge clk) disable iff (!rstN)
    $past(casN, 2) |-> !dqOe);

  // R10: a report always carries a real code
  a_r10_valid_has_kind: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |-> (cycleKind != 3'd0));

  // R10: no report means code zero
  a_r10_idle_kind_zero: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |-> (cycleKind == 3'd0));

endmodule

bind dram_cycle_decoder dram_cycle_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .casN      (casN),
  .weN       (weN),
  .oeN       (oeN),
  .dqOe      (dqOe),
  .earlyWrite(earlyWrite),
  .cycleValid(cycleValid),
  .cycleKind (cycleKind)
);

// File: tb/dram_cycle_decoder_bench.sv
module dram_cycle_decoder_bench;

  localparam int ADDR_W = 9;
  localparam int DATA_W = 4;

  localparam logic [2:0] K_READ = 3'd1, K_EARLY = 3'd2, K_LATE = 3'd3,
                         K_RMW = 3'd4, K_ROWREF = 3'd5, K_CBR = 3'd6,
                         K_HIDDEN = 3'd7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dqIn = '0;
  logic [DATA_W-1:0] dqOut;
  logic dqOe, earlyWrite, cycleValid;
  logic [2:0] cycleKind;
  logic [ADDR_W-1:0] cycleRow;

  always #5 clk = ~clk;

  dram_cycle_decoder u_dram_cycle_decoder (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .earlyWrite(earlyWrite), .cycleValid(cycleValid),
    .cycleKind(cycleKind), .cycleRow(cycleRow)
  );

  int checks = 0;
  int fails  = 0;
  string curReq = "R10";
  logic [2:0]        expKind[$];
  logic [ADDR_W-1:0] expRow[$];
  logic [DATA_W-1:0] model [int];
  int refCount = 0;
  logic [ADDR_W-1:0] curRow = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int key(logic [ADDR_W-1:0] r, logic [ADDR_W-1:0] c);
    return int'({r[2:0], c[2:0]});
  endfunction

  task automatic expect_evt(logic [2:0] k, logic [ADDR_W-1:0] r);
    expKind.push_back(k);
    expRow.push_back(r);
  endtask

  // per-clock comparison of report pulses against the model queue
  always @(negedge clk) begin
    if (rstN && cycleValid) begin
      if (expKind.size() == 0) begin
        chk({curReq, " unexpected report"}, {29'd0, cycleKind}, 32'd0);
      end else begin
        chk({curReq, " report kind"}, {29'd0, cycleKind}, {29'd0, expKind.pop_front()});
        chk({curReq, " report row"}, {23'd0, cycleRow}, {23'd0, expRow.pop_front()});
      end
    end
  end

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic drained();
    chk({curReq, " pending reports"}, expKind.size(), 0);
  endtask

  task automatic open_row(logic [ADDR_W-1:0] r);
    addr = r; rasN = 1'b0; curRow = r; step();
  endtask

  task automatic close_row();
    rasN = 1'b1; step();
  endtask

  task automatic early_wr(logic [ADDR_W-1:0] c, logic [DATA_W-1:0] d);
    curReq = "R2";
    addr = c; dqIn = d; weN = 1'b0; step();
    casN = 1'b0; step();
    chk("R2 early flag", {31'd0, earlyWrite}, 32'd1);
    oeN = 1'b0; step();
    chk("R2 bus released", {31'd0, dqOe}, 32'd0);
    expect_evt(K_EARLY, curRow);
    casN = 1'b1; weN = 1'b1; oeN = 1'b1; step();
    chk("R2 flag cleared", {31'd0, earlyWrite}, 32'd0);
    model[key(curRow, c)] = d;
    drained();
  endtask

  task automatic read_col(logic [ADDR_W-1:0] c);
    curReq = "R1";
    addr = c; casN = 1'b0; oeN = 1'b0; step();
    chk("R1 bus driven", {31'd0, dqOe}, 32'd1);
    chk("R1 read data", {28'd0, dqOut}, {28'd0, model[key(curRow, c)]});
    expect_evt(K_READ, curRow);
    casN = 1'b1; oeN = 1'b1; step();
    chk("R5 released after cas", {31'd0, dqOe}, 32'd0);
    drained();
  endtask

  initial begin
    logic [DATA_W-1:0] old;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'd0, cycleValid}, 32'd0);
    chk("R10 reset dqOe", {31'd0, dqOe}, 32'd0);
    chk("R10 reset early", {31'd0, earlyWrite}, 32'd0);
    rstN = 1'b1; step();

    // R2 / R1 / R6: page with writes then reads
    curReq = "R6";
    open_row(9'd2);
    early_wr(9'd1, 4'hA);
    early_wr(9'd2, 4'h5);
    early_wr(9'd3, 4'hC);
    read_col(9'd1);
    read_col(9'd3);
    read_col(9'd2);
    close_row();
    open_row(9'd6);
    early_wr(9'd1, 4'h3);
    read_col(9'd1);
    close_row();
    open_row(9'd2);
    read_col(9'd1);
    close_row();
    drained();

    // R1: output enable toggle re-drives read data
    curReq = "R1";
    open_row(9'd2);
    addr = 9'd3; casN = 1'b0; oeN = 1'b0; step();
    oeN = 1'b1; step();
    chk("R1 oe high releases", {31'd0, dqOe}, 32'd0);
    oeN = 1'b0; step();
    chk("R1 oe low redrives", {31'd0, dqOe}, 32'd1);
    chk("R1 redrive data", {28'd0, dqOut}, 32'hC);
    expect_evt(K_READ, 9'd2);
    casN = 1'b1; oeN = 1'b1; step();
    drained();

    // R3: late write with output enable high
    curReq = "R3";
    addr = 9'd1; casN = 1'b0; step();
    chk("R3 released before write", {31'd0, dqOe}, 32'd0);
    old = model[key(9'd2, 9'd1)];
    dqIn = 4'h7; weN = 1'b0; step();
    chk("R3 released during write", {31'd0, dqOe}, 32'd0);
    oeN = 1'b0; step();
    chk("R3 old data redriven", {31'd0, dqOe}, 32'd1);
    chk("R3 old data value", {28'd0, dqOut}, {28'd0, old});
    expect_evt(K_LATE, 9'd2);
    casN = 1'b1; oeN = 1'b1; weN = 1'b1; step();
    model[key(9'd2, 9'd1)] = 4'h7;
    drained();
    read_col(9'd1);

    // R4: read-modify-write
    curReq = "R4";
    addr = 9'd2; casN = 1'b0; oeN = 1'b0; step();
    old = model[key(9'd2, 9'd2)];
    chk("R4 read before write", {28'd0, dqOut}, {28'd0, old});
    dqIn = 4'h9; weN = 1'b0; step();
    chk("R4 still driven", {31'd0, dqOe}, 32'd1);
    chk("R4 old data kept", {28'd0, dqOut}, {28'd0, old});
    expect_evt(K_RMW, 9'd2);
    casN = 1'b1; oeN = 1'b1; weN = 1'b1; step();
    model[key(9'd2, 9'd2)] = 4'h9;
    drained();
    read_col(9'd2);
    close_row();

    // R7: row-only refresh
    curReq = "R7";
    open_row(9'h1A5);
    chk("R7 bus released", {31'd0, dqOe}, 32'd0);
    expect_evt(K_ROWREF, 9'h1A5);
    close_row();
    drained();

    // R8: counter refresh twice
    curReq = "R8";
    for (int i = 0; i < 2; i++) begin
      casN = 1'b0; step();
      rasN = 1'b0; step();
      chk("R8 bus released", {31'd0, dqOe}, 32'd0);
      expect_evt(K_CBR, 9'(refCount));
      refCount++;
      rasN = 1'b1; step();
      casN = 1'b1; step();
      drained();
    end

    // R9: hidden refresh after a read
    curReq = "R9";
    open_row(9'd6);
    addr = 9'd1; casN = 1'b0; oeN = 1'b0; step();
    rasN = 1'b1; step();
    chk("R9 held after ras high", {31'd0, dqOe}, 32'd1);
    rasN = 1'b0; step();
    chk("R9 held during refresh", {31'd0, dqOe}, 32'd1);
    chk("R9 held data", {28'd0, dqOut}, {28'd0, model[key(9'd6, 9'd1)]});
    expect_evt(K_HIDDEN, 9'(refCount));
    refCount++;
    rasN = 1'b1; step();
    drained();
    expect_evt(K_READ, 9'd6);
    casN = 1'b1; oeN = 1'b1; step();
    chk("R5 cleared after hidden", {31'd0, dqOe}, 32'd0);
    drained();

    // R8: counter continues after the hidden refresh
    curReq = "R8";
    casN = 1'b0; step();
    rasN = 1'b0; step();
    expect_evt(K_CBR, 9'(refCount));
    refCount++;
    rasN = 1'b1; step();
    casN = 1'b1; step();
    drained();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule